// File: doc/BRIEF.md
# Switchable Odd/Even Clock Divider with Banked Output Enables

This block divides one fast input clock by three or by four, picked by a select input. The duty cycle stays at an even half-and-half split for both ratios. The divide-by-three path uses both edges of the input clock to get there: a rising-edge phase pulse is widened by half an input period with a falling-edge copy. One shared divided signal feeds every output pin, so all enabled pins switch on the same input edge.

The outputs are grouped into banks of equal size, by default two banks of two pins. Each bank has its own enable. A disabled bank releases its pins to high impedance and lowers the matching per-pin drive-enable output, which a pad ring can use directly. A ratio change is held until the current divided period ends, so no short or stretched pulse appears. An active-low asynchronous reset stops the divider and holds the divided clock low. After reset is released, the first divided rising edge comes one full divided period later.

Top module: `cdiv_banked`

## Requirements
- R1: With `sel_div4` = 0, each divided period lasts 3 input periods. The divided clock rises with an input rising edge and stays high for 1.5 input periods, then low for 1.5 input periods.
- R2: With `sel_div4` = 1, each divided period lasts 4 input periods. The divided clock rises with an input rising edge and stays high for 2 input periods, then low for 2.
- R3: `sel_div4` is sampled only at the input rising edge that begins a divided period. A change made partway through a period leaves that period at its old ratio, and the next period takes the new ratio.
- R4: While `rst_n` is 0, every enabled output is low from the moment reset is asserted. After release, the first divided rising edge occurs on the N-th input rising edge, where N is the ratio selected at release.
- R5: `bank_en[0]` controls outputs 0 and 1. When it is 0, `clk_out_oe[1:0]` is 0 and those pins are high impedance. When it is 1, they drive the divided clock.
- R6: `bank_en[1]` controls outputs 2 and 3 in the same way, independently of `bank_en[0]`. All four enable combinations are valid.
- R7: All enabled outputs carry the same value at every instant, with zero relative skew.
- R8: Turning a bank off and on again does not disturb the divider phase. A re-enabled bank resumes exactly where an always-enabled bank would be.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_div4 | input | 1 | Ratio select: 0 divides by 3, 1 divides by 4 |
| bank_en | input | NUM_BANKS (2) | Per-bank output enable, bit b controls bank b |
| clk_out | output | NUM_BANKS*OUTS_PER_BANK (4) | Divided clock pins, high impedance when their bank is off |
| clk_out_oe | output | NUM_BANKS*OUTS_PER_BANK (4) | Per-pin drive enable for the pad ring |

## Verification
The hardest case to reach is a ratio switch that lands partway through a divided period. This matters most when the switch is from three to four or back while the falling-edge half-period stretch is still active. The stimulus changes `sel_div4` every few input cycles, at offsets that do not line up with the period, so the change falls at every possible phase of both ratios. The bench samples after every rising and every falling input edge. This exposes the 1.5-period high time of the odd ratio and any extra half period carried across the switch. Bank toggles and an asynchronous reset landing mid-period are mixed into the same run.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

   // high-phase length, in whole input periods, of the rising-edge phase pulse
   function automatic int rise_high_len(input int ratio);
      return (ratio % 2 == 1) ? (ratio - 1) / 2 : ratio / 2;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cdiv_phase_counter.sv
module cdiv_phase_counter
   import cdiv_pkg::*;
#(
   parameter int ODD_DIV  = 3,
   parameter int EVEN_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_even,
   output logic ratio_even,
   output logic rise_phase
);

   localparam int CNT_W = $clog2(max_of(ODD_DIV, EVEN_DIV));
   localparam logic [CNT_W-1:0] ODD_LAST  = CNT_W'(ODD_DIV - 1);
   localparam logic [CNT_W-1:0] EVEN_LAST = CNT_W'(EVEN_DIV - 1);
   localparam logic [CNT_W-1:0] ODD_HI    = CNT_W'(rise_high_len(ODD_DIV));
   localparam logic [CNT_W-1:0] EVEN_HI   = CNT_W'(rise_high_len(EVEN_DIV));

   logic [CNT_W-1:0] cnt_q, cnt_d, last_c, hi_c;
   logic             ratio_q, ratio_d;
   logic             started_q, started_d;
   logic             rise_q, rise_d;
   logic             wrap_c, load_c;

   always_comb begin
      last_c    = ratio_q ? EVEN_LAST : ODD_LAST;
      wrap_c    = (cnt_q >= last_c);
      cnt_d     = wrap_c ? '0 : cnt_q + 1'b1;
      load_c    = wrap_c | ~started_q;
      ratio_d   = load_c ? sel_even : ratio_q;
      started_d = started_q | wrap_c;
      hi_c      = ratio_d ? EVEN_HI : ODD_HI;
      rise_d    = started_d & (cnt_d < hi_c);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         ratio_q   <= 1'b1;
         started_q <= 1'b0;
         rise_q    <= 1'b0;
      end else begin
         cnt_q     <= cnt_d;
         ratio_q   <= ratio_d;
         started_q <= started_d;
         rise_q    <= rise_d;
      end
   end

   assign ratio_even = ratio_q;
   assign rise_phase = rise_q;

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started_q |-> (cnt_q <= (ratio_q ? EVEN_LAST : ODD_LAST)));

   // R3
   ratio_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && $past(started_q) && (ratio_q != $past(ratio_q))) |-> (cnt_q == '0));

   // R4
   prelude_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started_q |-> !rise_q);

endmodule

// File: rtl/cdiv_duty_shaper.sv
module cdiv_duty_shaper (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_phase,
   input  logic ratio_even,
   output logic div_clk
);

   logic half_q;

   // falling-edge copy, used only by the odd ratio to add half an input period
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) half_q <= 1'b0;
      else        half_q <= rise_phase & ~ratio_even;
   end

   assign div_clk = rise_phase | half_q;

   // R2
   even_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_even |-> !half_q);

endmodule

// File: rtl/cdiv_banked.sv
module cdiv_banked #(
   parameter int ODD_DIV       = 3,
   parameter int EVEN_DIV      = 4,
   parameter int NUM_BANKS     = 2,
   parameter int OUTS_PER_BANK = 2
) (
   input  logic                                clk_in,
   input  logic                                rst_n,
   input  logic                                sel_div4,
   input  logic [NUM_BANKS-1:0]                bank_en,
   output wire  [NUM_BANKS*OUTS_PER_BANK-1:0]  clk_out,
   output logic [NUM_BANKS*OUTS_PER_BANK-1:0]  clk_out_oe
);

   localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK;

   if (ODD_DIV % 2 != 1 || ODD_DIV < 3) begin : g_bad_odd
      $error("ODD_DIV must be an odd ratio of at least 3");
   end
   if (EVEN_DIV % 2 != 0 || EVEN_DIV < 2) begin : g_bad_even
      $error("EVEN_DIV must be an even ratio of at least 2");
   end
   if (NUM_BANKS < 1 || OUTS_PER_BANK < 1) begin : g_bad_banks
      $error("bank geometry must be non-empty");
   end

   logic ratio_even, rise_phase, div_clk;

   cdiv_phase_counter #(
      .ODD_DIV  (ODD_DIV),
      .EVEN_DIV (EVEN_DIV)
   ) u_counter (
      .clk        (clk_in),
      .rst_n      (rst_n),
      .sel_even   (sel_div4),
      .ratio_even (ratio_even),
      .rise_phase (rise_phase)
   );

   cdiv_duty_shaper u_shaper (
      .clk        (clk_in),
      .rst_n      (rst_n),
      .rise_phase (rise_phase),
      .ratio_even (ratio_even),
      .div_clk    (div_clk)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign clk_out_oe[b*OUTS_PER_BANK +: OUTS_PER_BANK] = {OUTS_PER_BANK{bank_en[b]}};
      assign clk_out[b*OUTS_PER_BANK +: OUTS_PER_BANK] =
         bank_en[b] ? {OUTS_PER_BANK{div_clk}} : {OUTS_PER_BANK{1'bz}};
   end

   // R7
   out_skew_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
      (bank_en[0] && bank_en[NUM_BANKS-1]) |-> (clk_out[0] == clk_out[NUM_OUTS-1]));

endmodule

// File: tb/cdiv_banked_tb.sv
module cdiv_banked_tb;

   logic       clk_in = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_div4 = 1'b1;
   logic [1:0] bank_en = 2'b11;
   wire  [3:0] clk_out;
   logic [3:0] clk_out_oe;

   int errors = 0;
   int checks = 0;

   // model state
   int    k = 0;
   int    s_start = 0;
   int    n_cur = 4;
   int    next_start = 4;
   bit    started = 1'b0;
   bit    in_reset = 1'b1;
   bit    clean = 1'b0;
   int    hi_cnt = 0;
   string tag = "R4";

   cdiv_banked u_dut (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .sel_div4   (sel_div4),
      .bank_en    (bank_en),
      .clk_out    (clk_out),
      .clk_out_oe (clk_out_oe)
   );

   always #5 clk_in = ~clk_in;

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   task automatic sample(input int h);
      logic       e;
      logic [3:0] oe_exp, mask;
      e      = started && ((h - 2 * s_start) < n_cur);
      oe_exp = {{2{bank_en[1]}}, {2{bank_en[0]}}};
      chk("R5", {2'b00, clk_out_oe[1:0]}, {2'b00, oe_exp[1:0]});
      chk("R6", {clk_out_oe[3:2], 2'b00}, {oe_exp[3:2], 2'b00});
      mask = oe_exp;
      chk(tag, clk_out & mask, {4{e}} & mask);
      if (bank_en == 2'b11)
         chk("R7", clk_out, {4{clk_out[0]}});
      if (bank_en[0] && clk_out[0] === 1'b1) hi_cnt++;
      if (!bank_en[0]) clean = 1'b0;
   endtask

   task automatic cycle;
      @(posedge clk_in);
      if (!in_reset) begin
         k++;
         if (k == next_start) begin
            if (started && clean)
               chk((n_cur == 3) ? "R1" : "R2", 4'(hi_cnt), 4'(n_cur));
            started    = 1'b1;
            s_start    = k;
            n_cur      = sel_div4 ? 4 : 3;
            next_start = k + n_cur;
            hi_cnt     = 0;
            clean      = 1'b1;
         end
      end
      #2 sample(2 * k);
      #5 sample(2 * k + 1);
      #1;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic do_reset(input logic sel);
      rst_n    = 1'b0;
      in_reset = 1'b1;
      started  = 1'b0;
      clean    = 1'b0;
      tag      = "R4";
      #1 chk("R4", clk_out & clk_out_oe, 4'b0000);
      sel_div4 = sel;
      run(3);
      rst_n      = 1'b1;
      in_reset   = 1'b0;
      k          = 0;
      s_start    = 0;
      next_start = sel ? 4 : 3;
      n_cur      = sel ? 4 : 3;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #3;
      do_reset(1'b1);
      tag = "R4";
      run(5);
      tag = "R2";
      run(30);
      // mid-period switch to the odd ratio
      run(1);
      sel_div4 = 1'b0;
      tag = "R3";
      run(3);
      tag = "R1";
      run(30);
      // switches at every offset
      tag = "R3";
      for (int i = 0; i < 24; i++) begin
         sel_div4 = ~sel_div4;
         run(2 + (i % 5));
      end
      // bank enable sweep while the ratio keeps moving
      tag = "R8";
      for (int r = 0; r < 3; r++) begin
         for (int c = 0; c < 4; c++) begin
            bank_en = 2'(c);
            run(5 + c);
            sel_div4 = ~sel_div4;
            run(4);
         end
      end
      bank_en = 2'b11;
      run(12);
      // reset arriving mid-period, odd ratio at release
      sel_div4 = 1'b0;
      run(2);
      do_reset(1'b0);
      run(4);
      tag = "R1";
      run(20);
      do_reset(1'b1);
      run(5);
      tag = "R2";
      run(12);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule